// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture and Aggregation Controller

This block sits between the inbound write path of a PCIe root port and the host interrupt controller. Message-signalled interrupts arrive as plain memory writes. The vector space holds 256 entries, grouped into 8 banks of 32. Each bank has its own programmable 64-bit landing address. When an inbound write hits the landing address of an enabled bank, the block records a pending flag in that bank. The write data gives the flag's bit position within the bank. The global vector number is the bank index times 32 plus that bit position.

Two levels of enable gate the pending flags: one mask bit per vector and one enable bit per bank. The gated bank summaries share a top-level status word with the four legacy INTx level inputs. A second enable word selects which of those status bits drive the single level-sensitive interrupt line. Software configures and services the block through a 32-bit register port with a write strobe and a combinational read-data mux. It clears a pending flag by writing a one to the flag's bit position.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Bank i (0..7) keeps its landing address split in two places. Bits 31:0 sit at offset 0xC00 + 16·i. Bits 63:32 sit in a separate bank at offset 0xC80 + 4·i. Both read back as written.
- R3: Bank i's pending word is at offset 0xC04 + 16·i. An inbound write is valid when `ib_wr_valid` is high, its 64-bit address equals bank i's landing address, its data d is below 32 and bank i is enabled. Such a write sets pending bit d of bank i at the next clock edge.
- R4: An inbound write is dropped with no state change if its data is 32 or more, or if its address matches no enabled bank.
- R5: Writing the pending word clears each bit written as one. Bits written as zero keep their value.
- R6: Suppose a capture and a software clear target the same pending bit in the same cycle. The bit ends set. Clears of other bits in that cycle still take effect.
- R7: The vector mask word is at offset 0xC08 + 16·i, where a one unmasks. Top-level status at 0x184 bit 8+i is high when bank i is enabled and at least one of its pending bits is unmasked.
- R8: The bank-enable word is at 0x190, bit i for bank i. A disabled bank captures nothing, and its status bit at 0x184 reads zero whatever its pending bits hold.
- R9: Status bits 27:24 at 0x184 follow the `intx_lvl` inputs (bit 24 = `intx_lvl[0]`). The status word is read-only, and writes to it change nothing.
- R10: The interrupt-enable word is at 0x180. Bits 15:8 are bank enables, bits 27:24 are INTx enables, and all other bits read zero. `irq_out` is high exactly while some status bit and its matching enable bit are both one. It is a level: it falls once those sources clear.
- R11: If two enabled banks hold the same landing address, only the lower-indexed bank captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ib_wr_valid | input | 1 | Inbound memory write present this cycle |
| ib_wr_addr | input | 64 | Inbound write address |
| ib_wr_data | input | 32 | Inbound write data (vector within bank) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| intx_lvl | input | 4 | Legacy INTx level sources |
| irq_out | output | 1 | Summary interrupt to host controller |

## Verification
The inbound capture path and the software clear of the pending word can act on the same bit in the same clock edge. The bench provokes this with one task that drives an inbound write and a register write in the same cycle. The first run targets the same bit already pending, and the result must read back still set. The second run clears a different bit while a new one is captured; both changes must appear together in the next read.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int DEF_NUM_SETS = 8;
  localparam int DEF_VECS     = 32;
  localparam int DW           = 32;
  localparam int REG_AW       = 12;
  localparam int INTX_N       = 4;

  localparam logic [REG_AW-1:0] OFS_INT_EN   = 12'h180;
  localparam logic [REG_AW-1:0] OFS_INT_STAT = 12'h184;
  localparam logic [REG_AW-1:0] OFS_SET_EN   = 12'h190;
  localparam int                GRP_BASE     = 'hC00;
  localparam int                GRP_STRIDE   = 'h10;
  localparam int                HI_BASE      = 'hC80;
  localparam int                HI_STRIDE    = 4;

  localparam int MSI_LSB  = 8;
  localparam int INTX_LSB = 24;
endpackage

// File: rtl/msi_vec_set.sv
module msi_vec_set #(
  parameter int VECS = msi_cap_pkg::DEF_VECS,
  parameter int DW   = msi_cap_pkg::DW,
  localparam int VEC_IDX_W = $clog2(VECS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_on,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic                 wr_stat,
  input  logic                 wr_mask,
  input  logic [DW-1:0]        wdata,
  input  logic [2*DW-1:0]      in_addr,
  input  logic                 in_ok,
  input  logic                 grant,
  input  logic [VEC_IDX_W-1:0] in_vec,
  output logic                 hit,
  output logic [DW-1:0]        land_lo,
  output logic [DW-1:0]        land_hi,
  output logic [VECS-1:0]      pend,
  output logic [VECS-1:0]      unmask,
  output logic                 summary
);
  logic [VECS-1:0] pend_nxt;
  logic [VECS-1:0] clr_bits;
  logic [VECS-1:0] set_bits;
  logic            pend_en;

  // Capture wins over a same-cycle clear of the same bit.
  always_comb begin
    clr_bits = wr_stat ? wdata[VECS-1:0] : '0;
    set_bits = grant ? (VECS'(1) << in_vec) : '0;
    pend_nxt = (pend & ~clr_bits) | set_bits;
    pend_en  = wr_stat | grant;
  end

  assign hit     = in_ok & set_on & (in_addr == {land_hi, land_lo});
  assign summary = |(pend & unmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      land_lo <= '0;
      land_hi <= '0;
      pend    <= '0;
      unmask  <= '0;
    end else begin
      if (wr_lo)   land_lo <= wdata;
      if (wr_hi)   land_hi <= wdata;
      if (pend_en) pend    <= pend_nxt;
      if (wr_mask) unmask  <= wdata[VECS-1:0];
    end
  end
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg #(
  parameter int NUM_SETS = msi_cap_pkg::DEF_NUM_SETS,
  parameter int INTX_N   = msi_cap_pkg::INTX_N,
  parameter int DW       = msi_cap_pkg::DW,
  parameter int MSI_LSB  = msi_cap_pkg::MSI_LSB,
  parameter int INTX_LSB = msi_cap_pkg::INTX_LSB
) (
  input  logic [NUM_SETS-1:0] set_sum,
  input  logic [NUM_SETS-1:0] set_on,
  input  logic [INTX_N-1:0]   intx,
  input  logic [DW-1:0]       int_en,
  output logic [DW-1:0]       int_stat,
  output logic                irq
);
  always_comb begin
    int_stat = '0;
    for (int s = 0; s < NUM_SETS; s++) int_stat[MSI_LSB+s] = set_sum[s] & set_on[s];
    for (int x = 0; x < INTX_N; x++)   int_stat[INTX_LSB+x] = intx[x];
  end

  assign irq = |(int_stat & int_en);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_SETS = DEF_NUM_SETS,
  parameter int VECS     = DEF_VECS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ib_wr_valid,
  input  logic [2*DW-1:0]   ib_wr_addr,
  input  logic [DW-1:0]     ib_wr_data,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [INTX_N-1:0] intx_lvl,
  output logic              irq_out
);
  localparam int SET_IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int VEC_IDX_W = $clog2(VECS);
  localparam int GIDX_W    = SET_IDX_W + VEC_IDX_W;
  localparam int TOTAL     = NUM_SETS * VECS;

  // Only the bank and INTx enable fields are implemented.
  localparam logic [DW-1:0] INT_EN_MASK =
    (((DW'(1) << NUM_SETS) - DW'(1)) << MSI_LSB) |
    (((DW'(1) << INTX_N) - DW'(1)) << INTX_LSB);

  logic [DW-1:0]        int_en_q,  int_en_d;
  logic [NUM_SETS-1:0]  set_en_q,  set_en_d;
  logic                 int_en_we, set_en_we;

  logic [NUM_SETS-1:0]  wr_lo, wr_hi, wr_stat, wr_mask;
  logic [NUM_SETS-1:0]  hit, grant, sum;
  logic [DW-1:0]        lo_r   [NUM_SETS];
  logic [DW-1:0]        hi_r   [NUM_SETS];
  logic [VECS-1:0]      pend_r [NUM_SETS];
  logic [VECS-1:0]      mask_r [NUM_SETS];
  logic [TOTAL-1:0]     pend_flat;
  logic [DW-1:0]        int_stat;
  logic                 in_ok;
  logic                 cap_fire;
  logic [SET_IDX_W-1:0] cap_set;
  logic [GIDX_W-1:0]    cap_gidx;

  assign in_ok = ib_wr_valid & (ib_wr_data < DW'(VECS));

  // Lowest-indexed matching bank takes the capture.
  always_comb begin
    grant   = '0;
    cap_set = '0;
    for (int s = NUM_SETS - 1; s >= 0; s--) begin
      if (hit[s]) begin
        grant   = '0;
        grant[s] = 1'b1;
        cap_set = SET_IDX_W'(s);
      end
    end
  end

  assign cap_fire = |hit;
  assign cap_gidx = {cap_set, ib_wr_data[VEC_IDX_W-1:0]};

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      localparam logic [REG_AW-1:0] A_LO   = REG_AW'(GRP_BASE + g * GRP_STRIDE);
      localparam logic [REG_AW-1:0] A_STAT = REG_AW'(GRP_BASE + g * GRP_STRIDE + 4);
      localparam logic [REG_AW-1:0] A_MASK = REG_AW'(GRP_BASE + g * GRP_STRIDE + 8);
      localparam logic [REG_AW-1:0] A_HI   = REG_AW'(HI_BASE + g * HI_STRIDE);

      assign wr_lo[g]   = reg_wr_en & (reg_addr == A_LO);
      assign wr_hi[g]   = reg_wr_en & (reg_addr == A_HI);
      assign wr_stat[g] = reg_wr_en & (reg_addr == A_STAT);
      assign wr_mask[g] = reg_wr_en & (reg_addr == A_MASK);

      msi_vec_set #(.VECS(VECS), .DW(DW)) i_set (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_on  (set_en_q[g]),
        .wr_lo   (wr_lo[g]),
        .wr_hi   (wr_hi[g]),
        .wr_stat (wr_stat[g]),
        .wr_mask (wr_mask[g]),
        .wdata   (reg_wdata),
        .in_addr (ib_wr_addr),
        .in_ok   (in_ok),
        .grant   (grant[g]),
        .in_vec  (ib_wr_data[VEC_IDX_W-1:0]),
        .hit     (hit[g]),
        .land_lo (lo_r[g]),
        .land_hi (hi_r[g]),
        .pend    (pend_r[g]),
        .unmask  (mask_r[g]),
        .summary (sum[g])
      );

      assign pend_flat[g*VECS +: VECS] = pend_r[g];
    end
  endgenerate

  msi_irq_agg #(
    .NUM_SETS (NUM_SETS),
    .INTX_N   (INTX_N),
    .DW       (DW),
    .MSI_LSB  (MSI_LSB),
    .INTX_LSB (INTX_LSB)
  ) i_agg (
    .set_sum  (sum),
    .set_on   (set_en_q),
    .intx     (intx_lvl),
    .int_en   (int_en_q),
    .int_stat (int_stat),
    .irq      (irq_out)
  );

  // Top-level enable registers: next state.
  always_comb begin
    int_en_we = reg_wr_en & (reg_addr == OFS_INT_EN);
    set_en_we = reg_wr_en & (reg_addr == OFS_SET_EN);
    int_en_d  = reg_wdata & INT_EN_MASK;
    set_en_d  = reg_wdata[NUM_SETS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= '0;
      set_en_q <= '0;
    end else begin
      if (int_en_we) int_en_q <= int_en_d;
      if (set_en_we) set_en_q <= set_en_d;
    end
  end

  // Read mux.
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_INT_EN)   reg_rdata = int_en_q;
    if (reg_addr == OFS_INT_STAT) reg_rdata = int_stat;
    if (reg_addr == OFS_SET_EN)   reg_rdata = DW'(set_en_q);
    for (int s = 0; s < NUM_SETS; s++) begin
      if (reg_addr == REG_AW'(GRP_BASE + s * GRP_STRIDE))     reg_rdata = lo_r[s];
      if (reg_addr == REG_AW'(GRP_BASE + s * GRP_STRIDE + 4)) reg_rdata = DW'(pend_r[s]);
      if (reg_addr == REG_AW'(GRP_BASE + s * GRP_STRIDE + 8)) reg_rdata = DW'(mask_r[s]);
      if (reg_addr == REG_AW'(HI_BASE + s * HI_STRIDE))       reg_rdata = hi_r[s];
    end
  end
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker #(
  parameter int NUM_SETS = 8,
  parameter int VECS     = 32,
  parameter int DW       = 32,
  parameter int MSI_LSB  = 8,
  parameter int GIDX_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ib_wr_valid,
  input logic [DW-1:0]            ib_wr_data,
  input logic                     cap_fire,
  input logic [GIDX_W-1:0]        cap_gidx,
  input logic [NUM_SETS*VECS-1:0] pend_flat,
  input logic [DW-1:0]            int_en,
  input logic [NUM_SETS-1:0]      set_en,
  input logic [DW-1:0]            int_stat,
  input logic                     irq_out
);
  // R3: a granted capture shows up in the pending array one edge later.
  assert_capture_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> pend_flat[$past(cap_gidx)]);

  // R4: an out-of-range vector sets no pending bit.
  assert_oversize_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_wr_valid && ib_wr_data >= DW'(VECS)) |=> ((pend_flat & ~$past(pend_flat)) == '0));

  // R5: without a capture no pending bit can rise.
  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> ((pend_flat & ~$past(pend_flat)) == '0));

  // R8: with every bank disabled no bank status bit is active.
  assert_banks_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en == '0) |-> (int_stat[MSI_LSB +: NUM_SETS] == '0));

  // R10: nothing enabled means no interrupt.
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq_out);
endmodule

bind msi_capture_ctrl msi_cap_checker #(
  .NUM_SETS (NUM_SETS),
  .VECS     (VECS),
  .DW       (msi_cap_pkg::DW),
  .MSI_LSB  (msi_cap_pkg::MSI_LSB),
  .GIDX_W   (GIDX_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ib_wr_valid (ib_wr_valid),
  .ib_wr_data  (ib_wr_data),
  .cap_fire    (cap_fire),
  .cap_gidx    (cap_gidx),
  .pend_flat   (pend_flat),
  .int_en      (int_en_q),
  .set_en      (set_en_q),
  .int_stat    (int_stat),
  .irq_out     (irq_out)
);

// File: tb/test_msi_capture_ctrl.sv
module test_msi_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  // op: 0 reg write, 1 reg read check, 2 inbound write (addr = bank, data = vector), 3 irq check
  localparam int NSTEP = 37;
  localparam logic [49:0] STEPS [NSTEP] = '{
    {2'd0, 4'd8,  12'h190, 32'h0000_00FF}, // R8 enable all banks
    {2'd0, 4'd2,  12'hC00, 32'hFEE0_0000}, // R2
    {2'd0, 4'd2,  12'hC80, 32'h0000_0100}, // R2
    {2'd0, 4'd2,  12'hC10, 32'hFEE0_0010}, // R2
    {2'd0, 4'd2,  12'hC84, 32'h0000_0101}, // R2
    {2'd0, 4'd2,  12'hC70, 32'hFEE0_0070}, // R2
    {2'd0, 4'd2,  12'hC9C, 32'h0000_0107}, // R2
    {2'd1, 4'd2,  12'hC70, 32'hFEE0_0070}, // R2
    {2'd1, 4'd2,  12'hC9C, 32'h0000_0107}, // R2
    {2'd2, 4'd3,  12'h000, 32'd5},         // R3
    {2'd1, 4'd3,  12'hC04, 32'h0000_0020}, // R3
    {2'd2, 4'd3,  12'h007, 32'd31},        // R3
    {2'd1, 4'd3,  12'hC74, 32'h8000_0000}, // R3
    {2'd1, 4'd7,  12'h184, 32'h0000_0000}, // R7 all masked
    {2'd0, 4'd7,  12'hC08, 32'h0000_0020}, // R7
    {2'd1, 4'd7,  12'h184, 32'h0000_0100}, // R7
    {2'd3, 4'd10, 12'h000, 32'd0},         // R10 not enabled
    {2'd0, 4'd10, 12'h180, 32'h0000_0100}, // R10
    {2'd3, 4'd10, 12'h000, 32'd1},         // R10
    {2'd2, 4'd4,  12'h001, 32'd40},        // R4 oversize
    {2'd1, 4'd4,  12'hC14, 32'h0000_0000}, // R4
    {2'd2, 4'd4,  12'h00F, 32'd3},         // R4 no match
    {2'd1, 4'd4,  12'hC14, 32'h0000_0000}, // R4
    {2'd0, 4'd5,  12'hC04, 32'h0000_0001}, // R5 zero bits keep
    {2'd1, 4'd5,  12'hC04, 32'h0000_0020}, // R5
    {2'd0, 4'd5,  12'hC04, 32'h0000_0020}, // R5
    {2'd1, 4'd5,  12'hC04, 32'h0000_0000}, // R5
    {2'd3, 4'd10, 12'h000, 32'd0},         // R10 level falls
    {2'd0, 4'd8,  12'h190, 32'h0000_007F}, // R8 bank 7 off
    {2'd2, 4'd8,  12'h007, 32'd2},         // R8
    {2'd1, 4'd8,  12'hC74, 32'h8000_0000}, // R8
    {2'd0, 4'd8,  12'hC78, 32'hFFFF_FFFF}, // R8
    {2'd1, 4'd8,  12'h184, 32'h0000_0000}, // R8
    {2'd0, 4'd8,  12'h190, 32'h0000_00FF}, // R8
    {2'd1, 4'd7,  12'h184, 32'h0000_8000}, // R7
    {2'd2, 4'd3,  12'h001, 32'd3},         // R3
    {2'd1, 4'd3,  12'hC14, 32'h0000_0008}  // R3
  };

  logic        clk;
  logic        rst_n;
  logic        ib_wr_valid;
  logic [63:0] ib_wr_addr;
  logic [31:0] ib_wr_data;
  logic        reg_wr_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_lvl;
  logic        irq_out;

  int n_run;
  int n_fail;

  msi_capture_ctrl i_msi_capture_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ib_wr_valid (ib_wr_valid),
    .ib_wr_addr  (ib_wr_addr),
    .ib_wr_data  (ib_wr_data),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .intx_lvl    (intx_lvl),
    .irq_out     (irq_out)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [63:0] land(input int b);
    return {32'h0000_0100 + 32'(b), 32'hFEE0_0000 + 32'(b * 16)};
  endfunction

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic inbound(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    ib_wr_valid = 1'b1; ib_wr_addr = a; ib_wr_data = d;
    @(negedge clk);
    ib_wr_valid = 1'b0;
  endtask

  task automatic both(input logic [63:0] ia, input logic [31:0] id,
                      input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk);
    ib_wr_valid = 1'b1; ib_wr_addr = ia; ib_wr_data = id;
    reg_wr_en = 1'b1; reg_addr = ra; reg_wdata = rd;
    @(negedge clk);
    ib_wr_valid = 1'b0; reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    n_run++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s reg %h: actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    #1;
    n_run++;
    if (irq_out !== exp) begin
      n_fail++;
      $display("FAIL %s irq_out: actual %b expected %b", tag, irq_out, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; ib_wr_valid = 1'b0; ib_wr_addr = '0; ib_wr_data = '0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; intx_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(12'h180, 32'h0, "R1");
    rd_chk(12'h184, 32'h0, "R1");
    rd_chk(12'h190, 32'h0, "R1");
    rd_chk(12'hC00, 32'h0, "R1");
    rd_chk(12'hC04, 32'h0, "R1");
    rd_chk(12'hC80, 32'h0, "R1");
    irq_chk(1'b0, "R1");

    for (int k = 0; k < NSTEP; k++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [11:0] ad;
      logic [31:0] dt;
      string       tag;
      {op, rq, ad, dt} = STEPS[k];
      tag = $sformatf("R%0d step %0d", rq, k);
      case (op)
        2'd0: reg_wr(ad, dt);
        2'd1: rd_chk(ad, dt, tag);
        2'd2: inbound(land(int'(ad)), dt);
        default: irq_chk(dt[0], tag);
      endcase
    end

    // R9 INTx mirrored, status write ignored
    intx_lvl = 4'b1010;
    rd_chk(12'h184, 32'h0A00_8000, "R9");
    reg_wr(12'h184, 32'hFFFF_FFFF);
    rd_chk(12'h184, 32'h0A00_8000, "R9");
    // R10 INTx enable drives the line, and it follows the level
    reg_wr(12'h180, 32'hFFFF_FFFF);
    rd_chk(12'h180, 32'h0F00_FF00, "R10");
    reg_wr(12'h180, 32'h0800_0000);
    irq_chk(1'b1, "R10");
    intx_lvl = 4'b0000;
    irq_chk(1'b0, "R10");

    // R6 capture and clear of the same bit in one cycle
    both(land(1), 32'd3, 12'hC14, 32'h0000_0008);
    rd_chk(12'hC14, 32'h0000_0008, "R6");
    both(land(1), 32'd4, 12'hC14, 32'h0000_0008);
    rd_chk(12'hC14, 32'h0000_0010, "R6");

    // R11 duplicate landing address: lowest bank wins
    reg_wr(12'hC20, 32'hFEE0_0010);
    reg_wr(12'hC88, 32'h0000_0101);
    inbound(land(1), 32'd6);
    rd_chk(12'hC14, 32'h0000_0050, "R11");
    rd_chk(12'hC24, 32'h0000_0000, "R11");
    reg_wr(12'h190, 32'h0000_00FD);
    inbound(land(1), 32'd7);
    rd_chk(12'hC24, 32'h0000_0080, "R11");
    rd_chk(12'hC14, 32'h0000_0050, "R8");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule